// File: doc/BRIEF.md
# Two-Output Priority Interrupt Controller

This controller gathers a wide set of level-sensitive peripheral request lines and turns them into two active-low requests toward a processor: a fast request and a normal request. Each source has a configuration entry. The entry holds an enable bit, a 4-bit priority, a routing bit that picks which output the source feeds, and a secure bit. A single global secure-mask flag stops secure-marked sources from reaching either output.

For each output, the block independently finds the best pending source. A source is pending only while its input line is high. It must also be enabled, routed to that output, and not blocked by the secure mask. The block then reports the source number of that winner with a valid flag and drives the matching request low. The search is a two-stage tree: fixed-size groups are reduced first, then the group winners. Outputs therefore trail the inputs by a fixed two clock edges.

Configuration is loaded one source at a time through a simple write port. The global mask has its own write strobe. All configuration and pipeline state is cleared only by the single asynchronous power-on/full reset.

Top module: `dual_irq_ctl`

## Requirements
- R1: After reset both request outputs are high, both valid flags are low, and every source is disabled, so raised input lines produce no request until sources are configured.
- R2: A source takes part only while its input line is high; when the line falls, the source stops being reported.
- R3: Among eligible sources on one output, the one with the numerically lowest 4-bit priority wins.
- R4: When eligible sources share the best priority, the lowest source number wins.
- R5: A routing bit of 1 sends a source to the fast output only; a routing bit of 0 sends it to the normal output only.
- R6: Each output runs its own arbitration, so a winner on one output never changes the result on the other.
- R7: A source whose enable bit is 0 never wins on either output.
- R8: While the global secure mask is 1, sources whose secure bit is 1 are blocked from both outputs. While the mask is 0, they are delivered like any other source. Non-secure sources are unaffected by the mask.
- R9: `nirq` is low exactly when `irq_vld` is 1, and `nfiq` is low exactly when `fiq_vld` is 1.
- R10: A change of `src_lvl` sampled at clock edge k is visible on the outputs after edge k+1. A configuration write sampled at edge k is visible after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on/full reset |
| src_lvl | input | N_SRC | Level-sensitive request lines, one per source |
| cfg_we | input | 1 | Write strobe for one source's configuration entry |
| cfg_idx | input | ID_W | Source number written; values at or above N_SRC are dropped |
| cfg_en | input | 1 | Enable bit to write |
| cfg_prio | input | PRIO_W | Priority to write (lower value is more urgent) |
| cfg_fast | input | 1 | Routing bit to write (1 = fast output) |
| cfg_secure | input | 1 | Secure bit to write |
| smask_we | input | 1 | Write strobe for the global secure mask |
| smask_d | input | 1 | Global secure mask value to write |
| nirq | output | 1 | Normal request, active low |
| nfiq | output | 1 | Fast request, active low |
| irq_id | output | ID_W | Winning source number on the normal output |
| irq_vld | output | 1 | Normal output has a winner |
| fiq_id | output | ID_W | Winning source number on the fast output |
| fiq_vld | output | 1 | Fast output has a winner |

## Verification
A corrupted configuration entry or group winner shows at the ports as a wrong winning ID, or as a valid flag on a source whose line is low. It appears two edges after the input that exposes it. The checker flags any reported winner whose line was not high two edges earlier, and any output valid while every line was low. It also flags a single source appearing on both outputs at once. The bench compares both ID/valid pairs against a reference arbitration after randomized configurations and line patterns, and also checks the exact edge at which a change first appears.

// File: rtl/dual_irq_ctl.sv
module dual_irq_ctl #(
  parameter  int N_SRC  = 480,
  parameter  int PRIO_W = 4,
  parameter  int GRP    = 32,
  localparam int ID_W   = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_lvl,
  input  logic              cfg_we,
  input  logic [ID_W-1:0]   cfg_idx,
  input  logic              cfg_en,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_fast,
  input  logic              cfg_secure,
  input  logic              smask_we,
  input  logic              smask_d,
  output logic              nirq,
  output logic              nfiq,
  output logic [ID_W-1:0]   irq_id,
  output logic              irq_vld,
  output logic [ID_W-1:0]   fiq_id,
  output logic              fiq_vld
);
  localparam int N_GRP = (N_SRC + GRP - 1) / GRP;

  logic [N_SRC-1:0]  en_q, fast_q, sec_q;
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic              smask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      fast_q  <= '0;
      sec_q   <= '0;
      smask_q <= 1'b0;
      for (int s = 0; s < N_SRC; s++) prio_q[s] <= '0;
    end else begin
      if (cfg_we && (int'(cfg_idx) < N_SRC)) begin
        en_q[cfg_idx]   <= cfg_en;
        fast_q[cfg_idx] <= cfg_fast;
        sec_q[cfg_idx]  <= cfg_secure;
        prio_q[cfg_idx] <= cfg_prio;
      end
      if (smask_we) smask_q <= smask_d;
    end
  end

  logic [N_SRC-1:0] live;
  assign live = src_lvl & en_q & ~(sec_q & {N_SRC{smask_q}});

  logic [1:0]      out_vld;
  logic [ID_W-1:0] out_id [2];

  for (genvar o = 0; o < 2; o++) begin : g_out
    logic [N_SRC-1:0]  el;
    logic [N_GRP-1:0]  gv_d, gv_q;
    logic [PRIO_W-1:0] gp_d [N_GRP];
    logic [PRIO_W-1:0] gp_q [N_GRP];
    logic [ID_W-1:0]   gi_d [N_GRP];
    logic [ID_W-1:0]   gi_q [N_GRP];
    logic              bv;
    logic [PRIO_W-1:0] bp;
    logic [ID_W-1:0]   bi;
    logic              vld_q;
    logic [ID_W-1:0]   id_q;

    assign el = (o == 1) ? (live & fast_q) : (live & ~fast_q);

    always_comb begin
      for (int g = 0; g < N_GRP; g++) begin
        gv_d[g] = 1'b0;
        gp_d[g] = '0;
        gi_d[g] = '0;
        for (int k = 0; k < GRP; k++) begin
          if (g * GRP + k < N_SRC) begin
            if (el[g*GRP+k] && (!gv_d[g] || prio_q[g*GRP+k] < gp_d[g])) begin
              gv_d[g] = 1'b1;
              gp_d[g] = prio_q[g*GRP+k];
              gi_d[g] = ID_W'(g * GRP + k);
            end
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gv_q <= '0;
        for (int g = 0; g < N_GRP; g++) begin
          gp_q[g] <= '0;
          gi_q[g] <= '0;
        end
      end else begin
        gv_q <= gv_d;
        for (int g = 0; g < N_GRP; g++) begin
          gp_q[g] <= gp_d[g];
          gi_q[g] <= gi_d[g];
        end
      end
    end

    always_comb begin
      bv = 1'b0;
      bp = '0;
      bi = '0;
      for (int g = 0; g < N_GRP; g++) begin
        if (gv_q[g] && (!bv || gp_q[g] < bp)) begin
          bv = 1'b1;
          bp = gp_q[g];
          bi = gi_q[g];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        id_q  <= '0;
      end else begin
        vld_q <= bv;
        id_q  <= bi;
      end
    end

    assign out_vld[o] = vld_q;
    assign out_id[o]  = id_q;
  end

  assign irq_vld = out_vld[0];
  assign irq_id  = out_id[0];
  assign fiq_vld = out_vld[1];
  assign fiq_id  = out_id[1];
  assign nirq    = ~out_vld[0];
  assign nfiq    = ~out_vld[1];
endmodule

// File: rtl/dual_irq_ctl_chk.sv
module dual_irq_ctl_chk #(
  parameter int N_SRC = 480,
  parameter int ID_W  = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_lvl,
  input logic             nirq,
  input logic             nfiq,
  input logic [ID_W-1:0]  irq_id,
  input logic             irq_vld,
  input logic [ID_W-1:0]  fiq_id,
  input logic             fiq_vld
);
  logic [N_SRC-1:0] src_d1, src_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d1 <= '0;
      src_d2 <= '0;
    end else begin
      src_d1 <= src_lvl;
      src_d2 <= src_d1;
    end
  end

  // R2
  irq_src_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vld |-> ((int'(irq_id) < N_SRC) && src_d2[irq_id]));

  // R2
  fiq_src_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_vld |-> ((int'(fiq_id) < N_SRC) && src_d2[fiq_id]));

  // R10
  quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_d2 == '0) |-> (!irq_vld && !fiq_vld));

  // R5
  single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vld && fiq_vld) |-> (irq_id != fiq_id));

  // R9
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nirq) |-> $rose(irq_vld));
endmodule

bind dual_irq_ctl dual_irq_ctl_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .nirq(nirq), .nfiq(nfiq),
  .irq_id(irq_id), .irq_vld(irq_vld), .fiq_id(fiq_id), .fiq_vld(fiq_vld)
);

// File: tb/dual_irq_ctl_tb.sv
`timescale 1ns/1ps
module dual_irq_ctl_tb;
  localparam int N  = 48;
  localparam int PW = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_lvl = '0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_fast = 1'b0, cfg_secure = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [PW-1:0] cfg_prio = '0;
  logic smask_we = 1'b0, smask_d = 1'b0;
  logic nirq, nfiq, irq_vld, fiq_vld;
  logic [IW-1:0] irq_id, fiq_id;

  always #2.5 clk = ~clk;

  dual_irq_ctl #(.N_SRC(N), .PRIO_W(PW), .GRP(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_en(cfg_en), .cfg_prio(cfg_prio), .cfg_fast(cfg_fast), .cfg_secure(cfg_secure),
    .smask_we(smask_we), .smask_d(smask_d), .nirq(nirq), .nfiq(nfiq),
    .irq_id(irq_id), .irq_vld(irq_vld), .fiq_id(fiq_id), .fiq_vld(fiq_vld));

  bit m_en [N];
  bit m_fast [N];
  bit m_sec [N];
  int m_prio [N];
  bit m_mask;
  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wr(int idx, bit en, int prio, bit fast, bit sec);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_en = en; cfg_prio = PW'(prio);
    cfg_fast = fast; cfg_secure = sec;
    tick();
    cfg_we = 1'b0;
    if (idx < N) begin
      m_en[idx] = en; m_prio[idx] = prio; m_fast[idx] = fast; m_sec[idx] = sec;
    end
  endtask

  task automatic set_mask(bit m);
    smask_we = 1'b1; smask_d = m;
    tick();
    smask_we = 1'b0;
    m_mask = m;
  endtask

  function automatic int expect_id(bit o);
    int best = -1;
    int bp = 0;
    for (int s = 0; s < N; s++) begin
      if (src_lvl[s] && m_en[s] && !(m_mask && m_sec[s]) && (m_fast[s] == o))
        if (best < 0 || m_prio[s] < bp) begin
          best = s; bp = m_prio[s];
        end
    end
    return best;
  endfunction

  task automatic check_all(string r);
    int ei = expect_id(1'b0);
    int ef = expect_id(1'b1);
    chk({r, " irq_vld"}, int'(irq_vld), int'(ei >= 0));
    chk({r, " fiq_vld"}, int'(fiq_vld), int'(ef >= 0));
    if (ei >= 0) chk({r, " irq_id"}, int'(irq_id), ei);
    if (ef >= 0) chk({r, " fiq_id"}, int'(fiq_id), ef);
    chk({r, " R9 nirq"}, int'(nirq), int'(ei < 0));
    chk({r, " R9 nfiq"}, int'(nfiq), int'(ef < 0));
  endtask

  initial begin
    #500000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < N; s++) begin
      m_en[s] = 0; m_fast[s] = 0; m_sec[s] = 0; m_prio[s] = 0;
    end
    m_mask = 0;
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1: idle after reset, all lines raised with nothing enabled
    chk("R1 nirq", int'(nirq), 1);
    chk("R1 nfiq", int'(nfiq), 1);
    src_lvl = '1;
    tick(3);
    chk("R1 irq_vld", int'(irq_vld), 0);
    chk("R1 fiq_vld", int'(fiq_vld), 0);
    src_lvl = '0;

    // R3 R4: priority then lowest index
    wr(5, 1, 7, 0, 0);
    wr(9, 1, 3, 0, 0);
    wr(12, 1, 3, 0, 0);
    wr(30, 1, 3, 0, 0);
    src_lvl[5] = 1; src_lvl[12] = 1; src_lvl[30] = 1;
    tick(3);
    chk("R3 lower prio wins", int'(irq_id), 12);
    src_lvl[9] = 1;
    tick(3);
    chk("R4 tie lowest index", int'(irq_id), 9);

    // R10: exact latency for line change
    src_lvl[9] = 0;
    tick();
    chk("R10 old id after one edge", int'(irq_id), 9);
    tick();
    chk("R10 new id after two edges", int'(irq_id), 12);

    // R10: config write latency (write sampled at edge k, visible after k+2)
    cfg_we = 1'b1; cfg_idx = IW'(5); cfg_en = 1; cfg_prio = 0; cfg_fast = 0; cfg_secure = 0;
    tick();
    cfg_we = 1'b0; m_prio[5] = 0;
    chk("R10 cfg not yet", int'(irq_id), 12);
    tick();
    chk("R10 cfg still old", int'(irq_id), 12);
    tick();
    chk("R10 cfg visible", int'(irq_id), 5);

    // R2: line falls -> dropped
    src_lvl = '0;
    tick(3);
    chk("R2 dropped", int'(irq_vld), 0);

    // R5 R6: routing and independent outputs
    wr(40, 1, 1, 1, 0);
    wr(41, 1, 0, 1, 0);
    src_lvl[40] = 1; src_lvl[41] = 1; src_lvl[12] = 1;
    tick(3);
    chk("R5 fast winner", int'(fiq_id), 41);
    chk("R6 normal unaffected", int'(irq_id), 12);
    check_all("R5 R6");

    // R7: disable
    wr(41, 0, 0, 1, 0);
    tick(3);
    chk("R7 disabled skipped", int'(fiq_id), 40);

    // R8: secure mask
    wr(40, 1, 1, 1, 1);
    set_mask(1);
    tick(3);
    chk("R8 secure blocked", int'(fiq_vld), 0);
    chk("R8 nonsecure kept", int'(irq_id), 12);
    set_mask(0);
    tick(3);
    chk("R8 secure passes unmasked", int'(fiq_id), 40);

    // random mixes
    for (int it = 0; it < 300; it++) begin
      int nw = $urandom_range(0, 4);
      for (int w = 0; w < nw; w++)
        wr($urandom_range(0, N - 1), 1'($urandom_range(0, 4) != 0), $urandom_range(0, 15),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 9) == 0) set_mask(~m_mask);
      for (int s = 0; s < N; s++) src_lvl[s] = ($urandom_range(0, 3) == 0);
      tick(3);
      check_all("R2 R3 R4 R5 R6 R7 R8 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule